// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

The controller gathers up to 32 level-sensitive requests from on-chip peripherals. It holds them against a per-source enable mask and picks one winner. It drives one level-sensitive request line to the host. The host programs and services the controller through four 32-bit registers on a simple synchronous register bus. Writes take effect at the clock edge that samples them. Reads are combinational from the register address.

The host services an interrupt in three steps. It writes 1 to bit 0 of the vector register. It reads the latched 5-bit vector from bits 15:11 of the same register. It ends the interrupt by writing 1 to that source's bit in the in-service register. Source 0 is not a peripheral: vector 0 is the error and spurious code. In-service bit 0 holds the error request. That request is raised when the host acknowledges after the request line was high, but a mask change has already removed every eligible source.

Register map (bus_addr): 0 configuration, 1 mask, 2 in-service, 3 vector. Configuration bits:
- [23:16] group order, four 2-bit slots. Slot k is at bits 16+2k and names a channel 0..3, that is, source 26 + channel.
- [15:13] request level.
- [12:8] preferred source.
- [7] global enable.
- [6:0] spare storage.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the mask, in-service and vector registers read 0, the configuration reads 0, and host_irq and host_err are low.
- R2: Mask bit i enables source i when 1. A masked source never causes host_irq.
- R3: host_irq and host_err are both gated by configuration bit 7 (global enable).
- R4: host_irq is high in the cycle after an edge at which an eligible source exists: pending and unmasked, with no in-service source of equal or higher rank.
- R5: A write of 1 to vector bit 0 latches the winner. The vector register then reads the winner in bits 15:11, with all other bits 0. Vector 0 is latched when no source is eligible.
- R6: Rank order runs as follows. First comes the preferred source, if it is nonzero and pending. Next come the four group slots in slot order 0..3. Last come the remaining sources in descending vector order.
- R7: An acknowledge sets the winner's in-service bit. An in-service source blocks sources of equal or lower rank until it is cleared. A higher-ranked source still wins.
- R8: Writing 1 to an in-service bit clears it. Writing 0 leaves it unchanged.
- R9: An acknowledge finds no eligible source while host_irq is high. It then latches vector 0 and sets in-service bit 0, which raises host_err. Writing 1 to in-service bit 0 clears that bit.
- R10: host_level always shows configuration bits 15:13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_req | input | 32 | Level requests, bit i is source i |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| host_irq | output | 1 | Level request to the host |
| host_err | output | 1 | Error request to the host |
| host_level | output | 3 | Configured request level |

## Verification
A register write lands at the edge that samples it. Read data follows combinationally, so the bench drives on the falling edge and reads back before the next rising edge. host_irq is registered, so it is due one edge after the requests, mask or in-service state that cause it. The bench therefore waits two edges after changing its stimulus before it checks the request line or acknowledges. The mask-race case issues the acknowledge at the edge directly after the mask write. At that edge host_irq still reflects the old mask, which is exactly the window that R9 covers.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NSRC     = 32;
  localparam int VW       = $clog2(NSRC);
  localparam int NGRP     = 4;
  localparam int GW       = 2;
  localparam int GRP_BASE = 26;
  localparam int CFGW     = NGRP * GW + 3 + VW + 1 + 7;

  typedef enum logic [1:0] {
    A_CFG  = 2'd0,
    A_MASK = 2'd1,
    A_ISR  = 2'd2,
    A_VEC  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [NGRP*GW-1:0] order;
    logic [2:0]         level;
    logic [VW-1:0]      top;
    logic               gen;
    logic [6:0]         spare;
  } cfg_t;
endpackage

// File: rtl/pic_prio.sv
module pic_prio
  import pic_pkg::*;
(
  input  logic [NSRC-1:0]    cand,
  input  logic [VW-1:0]      top_sel,
  input  logic [NGRP*GW-1:0] order,
  output logic               found,
  output logic [VW-1:0]      win
);
  logic [NGRP-1:0] slot_hit;
  logic [VW-1:0]   slot_src [NGRP];

  for (genvar k = 0; k < NGRP; k++) begin : g_slot
    assign slot_src[k] = VW'(GRP_BASE) + VW'(order[k*GW +: GW]);
    assign slot_hit[k] = cand[slot_src[k]];
  end

  logic          top_ok;
  logic          grp_ok;
  logic [VW-1:0] grp_win;
  logic          desc_ok;
  logic [VW-1:0] desc_win;

  assign top_ok = (top_sel != '0) && cand[top_sel];

  always_comb begin
    grp_ok  = 1'b0;
    grp_win = '0;
    for (int k = NGRP - 1; k >= 0; k--) begin
      if (slot_hit[k]) begin
        grp_ok  = 1'b1;
        grp_win = slot_src[k];
      end
    end
  end

  always_comb begin
    desc_ok  = 1'b0;
    desc_win = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (cand[i]) begin
        desc_ok  = 1'b1;
        desc_win = VW'(i);
      end
    end
  end

  always_comb begin
    found = top_ok | grp_ok | desc_ok;
    if (top_ok)      win = top_sel;
    else if (grp_ok) win = grp_win;
    else             win = desc_win;
  end
endmodule

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [1:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  input  logic            elig_i,
  input  logic [VW-1:0]   win_i,
  input  logic            irq_i,
  output cfg_t            cfg_q,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] isr_q,
  output logic [31:0]     bus_rdata
);
  logic [VW-1:0] vec_q, vec_d;
  cfg_t          cfg_d;
  logic [NSRC-1:0] mask_d, isr_d;
  logic wr_cfg, wr_mask, wr_isr, ack;

  assign wr_cfg  = bus_sel && bus_we && (bus_addr == A_CFG);
  assign wr_mask = bus_sel && bus_we && (bus_addr == A_MASK);
  assign wr_isr  = bus_sel && bus_we && (bus_addr == A_ISR);
  assign ack     = bus_sel && bus_we && (bus_addr == A_VEC) && bus_wdata[0];

  always_comb begin
    cfg_d  = wr_cfg  ? cfg_t'(bus_wdata[CFGW-1:0]) : cfg_q;
    mask_d = wr_mask ? bus_wdata[NSRC-1:0]         : mask_q;
    isr_d  = wr_isr  ? (isr_q & ~bus_wdata[NSRC-1:0]) : isr_q;
    vec_d  = vec_q;
    if (ack) begin
      if (elig_i) begin
        isr_d[win_i] = 1'b1;
        vec_d        = win_i;
      end else begin
        vec_d = '0;
        if (irq_i) isr_d[0] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '0;
      isr_q  <= '0;
      vec_q  <= '0;
    end else begin
      if (wr_cfg)           cfg_q  <= cfg_d;
      if (wr_mask)          mask_q <= mask_d;
      if (wr_isr || ack)    isr_q  <= isr_d;
      if (ack)              vec_q  <= vec_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = 32'(cfg_q);
      A_MASK:  bus_rdata = 32'(mask_q);
      A_ISR:   bus_rdata = 32'(isr_q);
      default: bus_rdata = {16'b0, vec_q, 11'b0};
    endcase
  end

  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_isr |=> ((isr_q & $past(bus_wdata[NSRC-1:0])) == '0));

  p_ack_sets_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && elig_i) |=> isr_q[$past(win_i)]);

  p_race_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !elig_i && irq_i) |=> (isr_q[0] && vec_q == '0));
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] src_req,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        host_irq,
  output logic        host_err,
  output logic [2:0]  host_level
);
  cfg_t            cfg_q;
  logic [NSRC-1:0] mask_q, isr_q, cand;
  logic            found, elig, irq_q, irq_d;
  logic [VW-1:0]   win;

  // Sources in service stay in the contest so they can block lower ranks.
  assign cand = ((src_req[NSRC-1:0] & mask_q) | isr_q) & ~NSRC'(1);
  assign elig = found && !isr_q[win];

  pic_prio u_prio (
    .cand    (cand),
    .top_sel (cfg_q.top),
    .order   (cfg_q.order),
    .found   (found),
    .win     (win)
  );

  pic_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .elig_i    (elig),
    .win_i     (win),
    .irq_i     (irq_q),
    .cfg_q     (cfg_q),
    .mask_q    (mask_q),
    .isr_q     (isr_q),
    .bus_rdata (bus_rdata)
  );

  assign irq_d = cfg_q.gen && elig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign host_irq   = irq_q;
  assign host_err   = cfg_q.gen && isr_q[0];
  assign host_level = cfg_q.level;

  p_irq_needs_gen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(cfg_q.gen));

  p_irq_needs_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(|(src_req[NSRC-1:0] & mask_q)));
endmodule

// File: tb/tb_pic_ctrl.sv
module tb_pic_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 7;

  localparam logic [31:0] T_REQ [NT] = '{32'h0000_0030, 32'h0000_0030, 32'h9800_0000,
                                         32'h9800_0000, 32'h8800_0000, 32'h0000_0208,
                                         32'h0000_0000};
  localparam logic [31:0] T_MSK [NT] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                         32'hFFFF_FFFF, 32'hF7FF_FFFF, 32'h0000_0008,
                                         32'hFFFF_FFFF};
  localparam logic [31:0] T_CFG [NT] = '{32'h00E4_0080, 32'h00E4_0480, 32'h00E4_0080,
                                         32'h00C6_0080, 32'h00E4_0080, 32'h00E4_0980,
                                         32'h00E4_0080};
  localparam logic [4:0]  T_EXP [NT] = '{5'd5, 5'd4, 5'd27, 5'd28, 5'd31, 5'd3, 5'd0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] src_req = '0, bus_wdata = '0, bus_rdata;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic host_irq, host_err;
  logic [2:0] host_level;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_ctrl dut (.clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .host_irq(host_irq), .host_err(host_err), .host_level(host_level));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [4:0] model(input logic [31:0] r, input logic [31:0] m,
                                       input logic [31:0] c);
    logic [31:0] cd;
    logic [4:0] s;
    cd = r & m & 32'hFFFF_FFFE;
    if (c[12:8] != 0 && cd[c[12:8]]) return c[12:8];
    for (int k = 0; k < 4; k++) begin
      s = 5'd26 + 5'(c[16+2*k +: 2]);
      if (cd[s]) return s;
    end
    for (int i = 31; i >= 1; i--) if (cd[i]) return 5'(i);
    return 5'd0;
  endfunction

  task automatic run_case(input string req, input logic [31:0] r, input logic [31:0] m,
                          input logic [31:0] c, input logic [4:0] e);
    logic [31:0] d;
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, c);
    wr(2'd1, m);
    src_req = r;
    settle();
    chk({req, " irq"}, 32'(host_irq), 32'(e != 0));
    wr(2'd3, 32'h1);
    rd(2'd3, d);
    chk({req, " vector"}, d, {16'b0, e, 11'b0});
    rd(2'd2, d);
    chk({req, " isr"}, d, (e != 0) ? (32'h1 << e) : 32'h0);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, d); chk("R1 cfg", d, 0);
    rd(2'd1, d); chk("R1 mask", d, 0);
    rd(2'd2, d); chk("R1 isr", d, 0);
    rd(2'd3, d); chk("R1 vec", d, 0);
    chk("R1 irq", 32'(host_irq), 0);
    chk("R1 err", 32'(host_err), 0);

    // R2 masked source stays silent
    wr(2'd0, 32'h00E4_0080);
    src_req = 32'h0000_0100;
    settle();
    chk("R2 masked", 32'(host_irq), 0);
    // R3 enable gate
    wr(2'd0, 32'h00E4_0000);
    wr(2'd1, 32'h0000_0100);
    settle();
    chk("R3 gen off", 32'(host_irq), 0);
    wr(2'd0, 32'h00E4_0080);
    @(negedge clk);
    chk("R4 irq one edge after enable", 32'(host_irq), 1);
    // R10 level field
    wr(2'd0, 32'h00E4_A080);
    chk("R10 level", 32'(host_level), 5);

    // R5 R6 table walk
    for (int t = 0; t < NT; t++) run_case("R5 R6 table", T_REQ[t], T_MSK[t], T_CFG[t], T_EXP[t]);

    // R7 blocking and preemption
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, 32'h00E4_0080);
    wr(2'd1, 32'hFFFF_FFFF);
    src_req = 32'h0000_0420;
    settle();
    wr(2'd3, 32'h1);
    rd(2'd3, d); chk("R7 first ack", d, {16'b0, 5'd10, 11'b0});
    settle();
    chk("R7 blocked irq", 32'(host_irq), 0);
    wr(2'd3, 32'h1);
    rd(2'd3, d); chk("R7 blocked ack", d, 0);
    chk("R7 no err when idle", 32'(host_err), 0);
    src_req = 32'h0010_0420;
    settle();
    chk("R7 higher raises irq", 32'(host_irq), 1);
    wr(2'd3, 32'h1);
    rd(2'd3, d); chk("R7 preempt", d, {16'b0, 5'd20, 11'b0});
    // R8 write-one-to-clear
    wr(2'd2, 32'h0);
    rd(2'd2, d); chk("R8 zero write", d, 32'h0010_0400);
    wr(2'd2, 32'h0010_0000);
    rd(2'd2, d); chk("R8 one write", d, 32'h0000_0400);

    // R9 mask race
    wr(2'd2, 32'hFFFF_FFFF);
    src_req = 32'h0000_0080;
    wr(2'd1, 32'h0000_0080);
    settle();
    chk("R9 irq before race", 32'(host_irq), 1);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h0;
    @(negedge clk);
    bus_addr = 2'd3; bus_wdata = 32'h1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    rd(2'd3, d); chk("R9 error vector", d, 0);
    chk("R9 err raised", 32'(host_err), 1);
    wr(2'd2, 32'h1);
    chk("R9 err cleared", 32'(host_err), 0);

    // R6 random patterns against the model
    for (int n = 0; n < 40; n++) begin
      logic [31:0] r, m, c;
      r = $urandom; m = $urandom;
      c = {8'h00, 8'($urandom), 3'b000, 5'($urandom), 8'h80};
      run_case("R6 random", r, m, c, model(r, m, c));
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule